// File: doc/BRIEF.md
# Double-Column Hit Capture with Cluster Timestamp

This block models one double column of a pixel matrix and the logic at its bottom edge. Every pixel keeps a one-bit hit register that is set by its front-end hit pulse or by a test-injection input, unless the pixel is masked. A priority encoder serves one stored hit per clock, lowest pixel index first. It clears that pixel and pushes its address into a small column FIFO. The FIFO presents its head word to a downstream reader.

A busy flag is raised while any hit is stored. The block runs a free-running timestamp counter. When busy goes from low to high, the counter value of that first busy cycle becomes the cluster timestamp. Every address drained before busy falls again is tagged with that one value, including hits that arrive in the middle of the episode. When the FIFO is full, the encoder waits, and no stored hit is cleared or lost.

Top module: `dcol_hit_capture`

## Requirements
- R1: While reset is low, `fifo_empty` is 1, `fifo_full` is 0, `busy` is 0 and `ts_now` is 0.
- R2: `ts_now` increases by one on every clock edge after reset and wraps modulo 2^TS_W.
- R3: Pixel i stores a hit on an edge where `hit_in[i]` or `test_inj[i]` is 1 and `mask[i]` is 0. A masked pixel never produces a FIFO entry. Setting `mask[i]` also drops a hit that pixel has already stored.
- R4: `busy` is 1 exactly while at least one hit is stored. For n hits captured on one edge with the reader keeping up, `busy` is high for n cycles. It falls in the cycle after the last of those hits is written.
- R5: At most one entry is written per edge, always for the stored hit with the lowest pixel index. An entry is {timestamp, address}, with the address in the low $clog2(NPIX) bits.
- R6: When `busy` rises, the cluster timestamp is the `ts_now` value of that first busy cycle. This is the value present right after the edge that captured the first hit.
- R7: All entries written during one busy episode carry the same timestamp. Hits captured while `busy` is already high join the episode and are ordered with the remaining hits by index.
- R8: While the FIFO holds FIFO_DEPTH entries, no entry is written and no stored hit is cleared. After space frees up, every stored hit is delivered in index order.
- R9: `rd_data` shows the oldest entry whenever `fifo_empty` is 0. `rd_en` removes that entry on the next edge. `rd_en` has no effect while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timestamp tick per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_in | input | NPIX | Front-end hit pulses, one per pixel |
| test_inj | input | NPIX | Test-injection hits, one per pixel |
| mask | input | NPIX | Per-pixel mask; 1 suppresses and drops hits |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | TS_W+$clog2(NPIX) | FIFO head {timestamp, address} |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| busy | output | 1 | Any hit stored in the column |
| ts_now | output | TS_W | Free-running timestamp counter |

## Verification
A hit driven before edge k is stored at edge k. `busy` is high from just after edge k, and the first entry is written at edge k+1. Each following stored hit takes one more edge, and the popped head is replaced one edge after `rd_en`. The bench therefore drives and samples only at falling edges. It takes the expected cluster timestamp from its own edge counter at the falling edge right after the capture edge. It counts the falling edges with `busy` high and compares that count with the number of unmasked hits. For the stall case, it waits well past the time needed to fill the FIFO before it checks that the FIFO is full and that the stored hits remain.

// File: rtl/dcol_hit_capture.sv
module dcol_hit_capture #(
  parameter int NPIX       = 16,
  parameter int TS_W       = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPIX-1:0]                  hit_in,
  input  logic [NPIX-1:0]                  test_inj,
  input  logic [NPIX-1:0]                  mask,
  input  logic                             rd_en,
  output logic [TS_W+$clog2(NPIX)-1:0]     rd_data,
  output logic                             fifo_empty,
  output logic                             fifo_full,
  output logic                             busy,
  output logic [TS_W-1:0]                  ts_now
);
  localparam int AW = $clog2(NPIX);
  localparam int EW = TS_W + AW;
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [NPIX-1:0] hit_q, grant, clr;
  logic [AW-1:0]   win_addr;
  logic [TS_W-1:0] ts_cnt, ts_lat, ep_ts;
  logic            busy_q, ep_start, push, pop;
  logic [EW-1:0]   mem [FIFO_DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [PW:0]     cnt;

  assign busy       = |hit_q;
  assign ep_start   = busy & ~busy_q;
  assign ep_ts      = ep_start ? ts_cnt : ts_lat;
  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt == (PW+1)'(FIFO_DEPTH));
  assign push       = busy & ~fifo_full;
  assign pop        = rd_en & ~fifo_empty;
  assign clr        = push ? grant : '0;
  assign rd_data    = mem[rp];
  assign ts_now     = ts_cnt;

  always_comb begin
    grant    = '0;
    win_addr = '0;
    for (int i = NPIX-1; i >= 0; i--) begin
      if (hit_q[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win_addr = AW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= '0;
      ts_cnt <= '0;
      ts_lat <= '0;
      busy_q <= 1'b0;
    end else begin
      hit_q  <= ((hit_q & ~clr) | hit_in | test_inj) & ~mask;
      ts_cnt <= ts_cnt + 1'b1;
      busy_q <= busy;
      if (ep_start) ts_lat <= ts_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(FIFO_DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(FIFO_DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {ep_ts, win_addr};
  end

  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_cnt == TS_W'($past(ts_cnt) + 1'b1));

  p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(push) || $past(|mask)));

  p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(hit_q) & ~hit_q & ~$past(mask)) <= 1);

  p_ts_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ep_start) |-> ep_ts == $past(ep_ts));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_en) |=> fifo_full);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(FIFO_DEPTH));
endmodule

// File: tb/dcol_hit_capture_bench.sv
`timescale 1ns/1ps
module dcol_hit_capture_bench;
  localparam int NPIX = 8;
  localparam int TS_W = 4;
  localparam int DEP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIX-1:0] hit_in = '0, test_inj = '0, mask = '0;
  logic rd_en = 1'b0;
  logic [TS_W+2:0] rd_data;
  logic fifo_empty, fifo_full, busy;
  logic [TS_W-1:0] ts_now;

  int checks = 0, fails = 0, bc = 0;
  bit done = 0;
  int exp_ord[16];
  int exp_n;

  always #4 clk = ~clk;
  always @(posedge clk) bc <= rst_n ? bc + 1 : 0;

  dcol_hit_capture #(.NPIX(NPIX), .TS_W(TS_W), .FIFO_DEPTH(DEP)) u_dcol_hit_capture (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .test_inj(test_inj), .mask(mask),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .busy(busy), .ts_now(ts_now));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic order_from(input logic [7:0] v);
    exp_n = 0;
    for (int i = 0; i < NPIX; i++) if (v[i]) begin exp_ord[exp_n] = i; exp_n++; end
  endtask

  task automatic inject(input logic [7:0] h, input logic [7:0] t, output int ts);
    hit_in = h; test_inj = t;
    @(posedge clk); @(negedge clk);
    hit_in = '0; test_inj = '0;
    ts = bc % 16;
  endtask

  task automatic drain(input int ts, input int exp_busy, input string req);
    int got = 0;
    int bcyc = 0;
    for (int c = 0; c < 80; c++) begin
      if (got == exp_n && !busy && fifo_empty) break;
      if (busy) bcyc++;
      if (!fifo_empty) begin
        chk(got < exp_n, req, rd_data, 0);
        if (got < exp_n)
          chk(rd_data == {ts[3:0], exp_ord[got][2:0]}, req, rd_data, {ts[3:0], exp_ord[got][2:0]});
        got++;
        rd_en = 1'b1;
      end else rd_en = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    rd_en = 1'b0;
    chk(got == exp_n, req, got, exp_n);
    if (exp_busy >= 0) chk(bcyc == exp_busy, "R4 busy cycles", bcyc, exp_busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ts;
    logic [7:0] mk;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(ts_now == 0, "R1 ts", ts_now, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // R9: read while empty has no effect
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(fifo_empty == 1'b1, "R9 empty read", fifo_empty, 1);
    inject(8'h04, 8'h00, ts);
    order_from(8'h04);
    drain(ts, 1, "R9 head after empty read");
    chk(fifo_empty == 1'b1, "R9 empty after pop", fifo_empty, 1);

    // R2/R3/R4/R5/R6: sweep all patterns, unmasked and masked
    for (int m = 0; m < 2; m++) begin
      mk = (m == 0) ? 8'h00 : 8'hA5;
      for (int p = 0; p < 256; p++) begin
        mask = mk;
        chk(ts_now == TS_W'(bc), "R2 counter", ts_now, bc % 16);
        inject(8'(p) & 8'h33, 8'(p) & 8'hCC, ts);
        order_from(8'(p) & ~mk);
        drain(ts, exp_n, (m == 0) ? "R5,R6 sweep" : "R3 masked sweep");
        mask = '0;
        @(posedge clk); @(negedge clk);
      end
    end

    // R7: hit arriving mid-episode joins it
    hit_in = 8'h0E;
    @(posedge clk); @(negedge clk);
    ts = bc % 16;
    hit_in = 8'h01;
    @(posedge clk); @(negedge clk);
    hit_in = 8'h00;
    exp_ord[0] = 1; exp_ord[1] = 0; exp_ord[2] = 2; exp_ord[3] = 3; exp_n = 4;
    drain(ts, -1, "R7 join");
    @(posedge clk); @(negedge clk);

    // R8: FIFO full stalls, no loss; R3: mask drops a pending hit
    inject(8'hFF, 8'h00, ts);
    repeat (12) begin @(posedge clk); @(negedge clk); end
    chk(fifo_full == 1'b1, "R8 full", fifo_full, 1);
    chk(busy == 1'b1, "R8 hits held", busy, 1);
    chk(rd_data == {ts[3:0], 3'd0}, "R8 head", rd_data, {ts[3:0], 3'd0});
    mask = 8'h80;
    @(posedge clk); @(negedge clk);
    mask = 8'h00;
    order_from(8'h7F);
    drain(ts, -1, "R8,R3 stall drain");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule